// File: doc/BRIEF.md
# Refresh and Bus Cycle Contention Arbiter

This block decides when a pending DRAM refresh may begin, given the bus cycle running at that moment. A refresh request arrives with its kind, either CAS-before-RAS or self-refresh. The arbiter compares that kind with the space and direction of the active bus cycle. If the two may overlap, the refresh starts at once and its RAS/CAS strobe enables are raised while the bus cycle is still in flight. If they may not overlap, the request is held and the refresh starts in the cycle after the bus cycle ends.

The block also works with the bus cycle sequencer. The sequencer asks to start a new bus cycle on `bus_req`, and `bus_gnt` tells it whether it may. A refresh that runs on its own, without a bus cycle, blocks new bus cycles until the refresh sequencer reports completion on `rfsh_done`. Requests that arrive while one is already waiting are merged into it and are not queued. The refresh kind latched with the first request is the one that is kept.

Top module: `refresh_arbiter`

## Requirements
- R1: A CAS-before-RAS refresh (`rfsh_self`=0) overlaps a read (`bus_write`=0) to external/multiplexed-I/O space (`bus_space`=2'b00). Against a write to that space it is deferred.
- R2: A self-refresh (`rfsh_self`=1) overlaps both reads and writes to external/multiplexed-I/O space (2'b00).
- R3: Neither refresh kind overlaps a DRAM-space cycle (2'b01; code 2'b11 is handled the same way). The refresh starts in the cycle after `bus_active` is first sampled low.
- R4: Both refresh kinds overlap on-chip accesses (2'b10), whether read or write.
- R5: When no bus cycle is active, a request sampled at a clock edge produces `rfsh_start` in the cycle right after that edge.
- R6: `rfsh_start` is a one-cycle pulse. `rfsh_busy`, `ras_en` and `cas_en` rise together with it and stay high until the cycle after `rfsh_done` is sampled.
- R7: Several requests received while one is waiting produce exactly one refresh. The refresh kind of the first request is kept.
- R8: A request that arrives while a refresh is busy is held. It starts its own refresh one cycle after the running refresh ends.
- R9: `bus_gnt` follows `bus_req`, except that it is low while a non-overlapped refresh is busy and in the cycle in which such a refresh is being launched.
- R10: `rfsh_parallel` is high for the whole of a refresh that began while a bus cycle was active, and low for one that began on an idle bus.
- R11: During reset and in the first cycle after it, every refresh output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rfsh_req | input | 1 | Refresh wanted (pulse or level) |
| rfsh_self | input | 1 | Refresh kind: 0 CAS-before-RAS, 1 self-refresh |
| bus_active | input | 1 | A bus cycle is in progress |
| bus_space | input | 2 | Target space of the active cycle: 00 external/mux I/O, 01 DRAM, 10 on-chip, 11 treated as DRAM |
| bus_write | input | 1 | Active cycle is a write |
| bus_req | input | 1 | Sequencer asks to start a new bus cycle |
| bus_gnt | output | 1 | New bus cycle may start this cycle |
| rfsh_done | input | 1 | Refresh sequencer reports refresh finished |
| rfsh_start | output | 1 | One-cycle refresh launch pulse |
| rfsh_busy | output | 1 | Refresh in progress |
| rfsh_parallel | output | 1 | Current refresh overlaps a bus cycle |
| ras_en | output | 1 | RAS refresh strobe enable |
| cas_en | output | 1 | CAS refresh strobe enable |

## Verification
The bench runs every pairing of refresh kind with space and direction. The CAS-before-RAS case against an external write is the one most easily got wrong: a design that merged the table rows would overlap it and corrupt the write. A deferred refresh is checked in two ways. It must stay silent for as long as the bus stays active. It must then start exactly one cycle after the bus goes idle, so a design that drops the request, or starts it a cycle late, fails. Merging is checked by first deferring a CAS-before-RAS request and then adding a self-refresh request. A design that let the later kind overwrite the first would start the refresh during an external write. Grant blocking is checked both during a stand-alone refresh and during an overlapped one, and in the cycle of a launch on an idle bus, where the refresh must win over a new bus cycle.

// File: rtl/refarb_pkg.sv
package refarb_pkg;
  localparam int SPACE_W = 2;

  typedef enum logic [SPACE_W-1:0] {
    SP_EXT   = 2'b00,
    SP_DRAM  = 2'b01,
    SP_ONCHP = 2'b10,
    SP_RSVD  = 2'b11
  } space_e;

  typedef enum logic {
    RK_CBR  = 1'b0,
    RK_SELF = 1'b1
  } rkind_e;
endpackage

// File: rtl/refarb_overlap.sv
module refarb_overlap
  import refarb_pkg::*;
(
  input  logic               kind,
  input  logic [SPACE_W-1:0] space,
  input  logic               wr,
  output logic               ok
);
  always_comb begin
    unique case (space)
      SP_EXT:   ok = (kind == RK_SELF) || !wr;
      SP_ONCHP: ok = 1'b1;
      default:  ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/refarb_pending.sv
module refarb_pending (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic req_kind,
  input  logic consume,
  output logic eff_pend,
  output logic eff_kind
);
  logic pend_q;
  logic kind_q;

  assign eff_pend = pend_q | req;
  assign eff_kind = pend_q ? kind_q : req_kind;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      kind_q <= 1'b0;
    end else begin
      if (consume)     pend_q <= 1'b0;
      else if (req)    pend_q <= 1'b1;
      if (!pend_q && req) kind_q <= req_kind;
    end
  end

  // R7
  kind_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !consume) |=> (pend_q && $stable(kind_q)));
endmodule

// File: rtl/refarb_ctrl.sv
module refarb_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic eff_pend,
  input  logic overlap_ok,
  input  logic bus_active,
  input  logic bus_req,
  input  logic rfsh_done,
  output logic launch,
  output logic bus_gnt,
  output logic start_q,
  output logic busy_q,
  output logic par_q
);
  logic solo_launch;

  assign launch      = eff_pend && !busy_q && (!bus_active || overlap_ok);
  assign solo_launch = launch && !bus_active;
  assign bus_gnt     = bus_req && !(busy_q && !par_q) && !solo_launch;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      busy_q  <= 1'b0;
      par_q   <= 1'b0;
    end else begin
      start_q <= launch;
      if (launch) begin
        busy_q <= 1'b1;
        par_q  <= bus_active;
      end else if (rfsh_done) begin
        busy_q <= 1'b0;
        par_q  <= 1'b0;
      end
    end
  end

  // R6
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);
  // R6
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(rfsh_done));
  // R6
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> start_q);
endmodule

// File: rtl/refresh_arbiter.sv
module refresh_arbiter
  import refarb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rfsh_req,
  input  logic               rfsh_self,
  input  logic               bus_active,
  input  logic [SPACE_W-1:0] bus_space,
  input  logic               bus_write,
  input  logic               bus_req,
  output logic               bus_gnt,
  input  logic               rfsh_done,
  output logic               rfsh_start,
  output logic               rfsh_busy,
  output logic               rfsh_parallel,
  output logic               ras_en,
  output logic               cas_en
);
  logic eff_pend, eff_kind, ok, launch;
  logic start_q, busy_q, par_q;

  refarb_overlap u_ovl (
    .kind(eff_kind), .space(bus_space), .wr(bus_write), .ok(ok)
  );

  refarb_pending u_pend (
    .clk(clk), .rst_n(rst_n), .req(rfsh_req), .req_kind(rfsh_self),
    .consume(launch), .eff_pend(eff_pend), .eff_kind(eff_kind)
  );

  refarb_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .eff_pend(eff_pend), .overlap_ok(ok),
    .bus_active(bus_active), .bus_req(bus_req), .rfsh_done(rfsh_done),
    .launch(launch), .bus_gnt(bus_gnt), .start_q(start_q),
    .busy_q(busy_q), .par_q(par_q)
  );

  assign rfsh_start    = start_q;
  assign rfsh_busy     = busy_q;
  assign rfsh_parallel = busy_q & par_q;
  assign ras_en        = busy_q;
  assign cas_en        = busy_q;

  // R3
  no_dram_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rfsh_start && rfsh_parallel) |-> ($past(bus_space) == SP_EXT ||
                                       $past(bus_space) == SP_ONCHP));
  // R1
  cbr_ext_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rfsh_start && rfsh_parallel && $past(bus_space) == SP_EXT && $past(bus_write))
      |-> $past(eff_kind) == RK_SELF);
  // R9
  solo_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rfsh_busy && !rfsh_parallel) |-> !bus_gnt);
  // R10
  par_needs_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rfsh_start && rfsh_parallel) |-> $past(bus_active));
endmodule

// File: tb/tb_refresh_arbiter.sv
module tb_refresh_arbiter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rfsh_req = 0, rfsh_self = 0, bus_active = 0, bus_write = 0;
  logic bus_req = 0, rfsh_done = 0;
  logic [1:0] bus_space = 2'b00;
  logic bus_gnt, rfsh_start, rfsh_busy, rfsh_parallel, ras_en, cas_en;
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  refresh_arbiter dut (
    .clk(clk), .rst_n(rst_n), .rfsh_req(rfsh_req), .rfsh_self(rfsh_self),
    .bus_active(bus_active), .bus_space(bus_space), .bus_write(bus_write),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .rfsh_done(rfsh_done),
    .rfsh_start(rfsh_start), .rfsh_busy(rfsh_busy),
    .rfsh_parallel(rfsh_parallel), .ras_en(ras_en), .cas_en(cas_en)
  );

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic finish_refresh(string req);
    rfsh_done = 1; tick(); rfsh_done = 0;
    chk(req, "busy after done", rfsh_busy, 0);
    chk(req, "ras after done", ras_en, 0);
    chk(req, "cas after done", cas_en, 0);
  endtask

  task automatic t_reset();
    chk("R11", "start in reset", rfsh_start, 0);
    chk("R11", "busy in reset", rfsh_busy, 0);
    rst_n = 1; tick();
    chk("R11", "busy after reset", rfsh_busy, 0);
    chk("R11", "ras after reset", ras_en, 0);
    chk("R11", "par after reset", rfsh_parallel, 0);
    bus_req = 1; #1 chk("R9", "gnt idle", bus_gnt, 1); bus_req = 0;
  endtask

  task automatic t_idle();
    rfsh_req = 1; rfsh_self = 0; tick(); rfsh_req = 0;
    chk("R5", "start next cycle", rfsh_start, 1);
    chk("R6", "busy with start", rfsh_busy, 1);
    chk("R6", "ras with start", ras_en, 1);
    chk("R6", "cas with start", cas_en, 1);
    chk("R10", "solo not parallel", rfsh_parallel, 0);
    tick();
    chk("R6", "start one cycle", rfsh_start, 0);
    chk("R6", "busy holds", rfsh_busy, 1);
    tick();
    chk("R6", "busy holds until done", rfsh_busy, 1);
    finish_refresh("R6");
  endtask

  task automatic t_pair(string req, logic kind, logic [1:0] sp, logic wr, logic exp_par);
    bus_active = 1; bus_space = sp; bus_write = wr;
    rfsh_self = kind; rfsh_req = 1; tick(); rfsh_req = 0;
    if (exp_par) begin
      chk(req, "parallel start", rfsh_start, 1);
      chk("R10", "parallel flag", rfsh_parallel, 1);
      bus_req = 1; #1 chk("R9", "gnt during overlap", bus_gnt, 1); bus_req = 0;
      bus_active = 0; tick();
      chk("R10", "parallel flag holds", rfsh_parallel, 1);
      chk("R6", "no second start", rfsh_start, 0);
    end else begin
      chk(req, "deferred no start", rfsh_start, 0);
      tick();
      chk(req, "still deferred", rfsh_busy, 0);
      bus_active = 0; tick();
      chk(req, "start after bus end", rfsh_start, 1);
      chk("R10", "deferred not parallel", rfsh_parallel, 0);
      bus_req = 1; #1 chk("R9", "gnt blocked solo", bus_gnt, 0); bus_req = 0;
    end
    finish_refresh(req);
  endtask

  task automatic t_merge();
    bus_active = 1; bus_space = 2'b01; bus_write = 0;
    rfsh_self = 0; rfsh_req = 1; tick();
    rfsh_self = 1; tick();
    rfsh_req = 0; tick();
    rfsh_req = 1; tick(); rfsh_req = 0;
    bus_space = 2'b00; bus_write = 1; tick();
    chk("R7", "first kind kept", rfsh_start, 0);
    tick();
    chk("R7", "still waiting", rfsh_busy, 0);
    bus_active = 0; tick();
    chk("R7", "single start", rfsh_start, 1);
    finish_refresh("R7");
    for (int i = 0; i < 4; i++) begin
      tick();
      chk("R7", "no queued repeat", rfsh_start, 0);
    end
  endtask

  task automatic t_req_busy();
    rfsh_req = 1; rfsh_self = 0; tick(); rfsh_req = 0;
    chk("R8", "first start", rfsh_start, 1);
    rfsh_req = 1; tick(); rfsh_req = 0;
    chk("R8", "no start while busy", rfsh_start, 0);
    rfsh_done = 1; tick(); rfsh_done = 0;
    chk("R8", "busy dropped", rfsh_busy, 0);
    chk("R8", "not yet restarted", rfsh_start, 0);
    tick();
    chk("R8", "held request starts", rfsh_start, 1);
    finish_refresh("R8");
  endtask

  task automatic t_launch_conflict();
    rfsh_req = 1; bus_req = 1; #1
    chk("R9", "gnt low at solo launch", bus_gnt, 0);
    tick(); rfsh_req = 0;
    chk("R9", "gnt low during solo", bus_gnt, 0);
    bus_req = 0;
    finish_refresh("R9");
    bus_req = 1; #1 chk("R9", "gnt restored", bus_gnt, 1); bus_req = 0;
  endtask

  initial begin
    repeat (3) tick();
    t_reset();
    t_idle();
    t_pair("R1", 0, 2'b00, 0, 1);
    t_pair("R1", 0, 2'b00, 1, 0);
    t_pair("R2", 1, 2'b00, 0, 1);
    t_pair("R2", 1, 2'b00, 1, 1);
    t_pair("R3", 0, 2'b01, 0, 0);
    t_pair("R3", 1, 2'b01, 1, 0);
    t_pair("R3", 1, 2'b11, 0, 0);
    t_pair("R4", 0, 2'b10, 1, 1);
    t_pair("R4", 1, 2'b10, 0, 1);
    t_merge();
    t_req_busy();
    t_launch_conflict();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule